// File: doc/BRIEF.md
# Periodic Compare Timer

This block is a 32-bit down-counter behind a small word-addressed register bus. Software picks one of three count-enable strobes as the count source and divides it by a programmable prescaler. It also picks how the counter behaves when it passes zero: restart from a programmed load value, or wrap to all ones. A compare register raises a sticky flag when the counter steps onto the compare value, and that flag drives a level interrupt that software gates and acknowledges.

Five word registers are reachable: control, status, load, compare and the live count. A load write can overwrite the running count at once. Setting enable with the start-mode bit restarts the count from a known value. A software-reset bit returns the datapath to its reset values but keeps the enable and power-mode bits that were written with it.

Top module: `ctm_timer`

## Requirements
- R1: The register index is `bus_addr >> 2`. Index 0 is control, 1 is status, 2 is load, 3 is compare and 4 is count. `bus_rdata` shows the addressed register combinationally. Any other index reads as zero, and a write to it changes no register.
- R2: A control write keeps bits 25:0 only. Bits 31:26 read as zero. The software-reset bit 16 always reads as zero.
- R3: Control bits 25:24 select the count strobe: 0 none, 1 `src_en_per`, 2 `src_en_fast`, 3 `src_en_slow`. Bits 15:4 hold P, and the counter steps once per P+1 strobes of the selected source.
- R4: `irq` is high exactly while the status flag, the compare-interrupt enable (bit 2) and the timer enable (bit 0) are all set. It falls in the cycle after a write clears any of them.
- R5: A status write with bit 0 set clears the flag. A status write with bit 0 clear leaves it unchanged.
- R6: A control write with bit 16 set stores only bits 0, 1, 18, 19, 20 and 21 of the written value. It also clears status, compare and count, and sets load to 0xFFFFFFFF.
- R7: A write that sets enable (bit 0) from 0 while start-mode (bit 1) is set loads the count. The count becomes the load value when reload mode (bit 3) is set, and 0xFFFFFFFF otherwise.
- R8: A load write always updates the load value. It also replaces the count in the same cycle when the overwrite bit (bit 17) is set, and leaves the count untouched when that bit is clear.
- R9: On each prescaled step the count decrements. From zero it takes the load value in reload mode, and 0xFFFFFFFF otherwise.
- R10: While enable is clear, source strobes do not move the count.
- R11: The status flag is set on a step whose new count equals the compare value, and only while enable and compare-interrupt enable are both set.
- R12: After reset, control, status, compare and count read zero, load reads 0xFFFFFFFF, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en_per | input | 1 | Peripheral-rate count strobe |
| src_en_fast | input | 1 | High-rate count strobe |
| src_en_slow | input | 1 | Low-rate count strobe |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write when high together with bus_sel |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq | output | 1 | Level compare interrupt |

## Verification
The bench builds the block with its defaults: an 8-bit byte address and a 12-bit prescaler. The address width leaves many unmapped word indices above the count register, so decode holes can be probed. The bench drives each count strobe for an exact number of cycles, which makes prescaler division, source selection and zero crossings land on known counts. The overwrite path places the counter a few steps from zero, so wrap, reload and compare events happen in a handful of cycles instead of after 2^32 steps.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    localparam int DW      = 32;
    localparam int PRESC_W = 12;
    localparam int CTRL_W  = 26;

    // Control word layout, bit 25 down to bit 0
    typedef struct packed {
        logic [1:0]         clk_src;    // 25:24
        logic [1:0]         spare;      // 23:22
        logic               stop_en;    // 21
        logic               doze_en;    // 20
        logic               wait_en;    // 19
        logic               dbg_en;     // 18
        logic               ovw;        // 17 load write overwrites count
        logic               swr;        // 16 software reset
        logic [PRESC_W-1:0] presc;      // 15:4
        logic               reload;     // 3
        logic               cmp_ie;     // 2
        logic               start_mode; // 1
        logic               en;         // 0
    } ctrl_t;

    // Bits surviving a software reset: en, start_mode, dbg/wait/doze/stop
    localparam logic [CTRL_W-1:0] SWR_KEEP = 26'h03C_0003;

    typedef enum logic [2:0] {
        REG_CTRL = 3'd0,
        REG_STAT = 3'd1,
        REG_LOAD = 3'd2,
        REG_CMP  = 3'd3,
        REG_CNT  = 3'd4
    } reg_idx_e;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_PER  = 2'd1,
        SRC_FAST = 2'd2,
        SRC_SLOW = 2'd3
    } clk_src_e;

    function automatic ctrl_t ctrl_from_word(input logic [DW-1:0] w);
        return ctrl_t'(w[CTRL_W-1:0]);
    endfunction

    function automatic logic [DW-1:0] step_value(input logic [DW-1:0] cur,
                                                 input logic reload,
                                                 input logic [DW-1:0] load);
        if (cur == '0) return reload ? load : '1;
        return cur - DW'(1);
    endfunction

endpackage

// File: rtl/ctm_prescale.sv
module ctm_prescale
    import ctm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [1:0]         src,
    input  logic [PRESC_W-1:0] presc,
    input  logic               src_en_per,
    input  logic               src_en_fast,
    input  logic               src_en_slow,
    output logic               tick
);
    logic               sel_en;
    logic [PRESC_W-1:0] div_cnt;
    logic               div_hit;

    always_comb begin
        case (clk_src_e'(src))
            SRC_PER:  sel_en = src_en_per;
            SRC_FAST: sel_en = src_en_fast;
            SRC_SLOW: sel_en = src_en_slow;
            default:  sel_en = 1'b0;
        endcase
    end

    assign div_hit = (div_cnt >= presc);
    assign tick    = en && sel_en && div_hit;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_cnt <= '0;
        end else if (sel_en) begin
            div_cnt <= div_hit ? '0 : div_cnt + PRESC_W'(1);
        end
    end

endmodule

// File: rtl/ctm_counter.sv
module ctm_counter
    import ctm_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          swr_p,
    input  logic          start_p,
    input  logic [DW-1:0] start_val,
    input  logic          ovw_p,
    input  logic [DW-1:0] ovw_val,
    input  logic          reload,
    input  logic [DW-1:0] load_q,
    input  logic [DW-1:0] cmp_q,
    input  logic          cmp_arm,
    input  logic          stat_clr_p,
    output logic [DW-1:0] count_q,
    output logic          status_q
);
    logic [DW-1:0] next_step;
    logic          step_now;
    logic          cmp_hit;

    assign next_step = step_value(count_q, reload, load_q);
    assign step_now  = tick && !ovw_p && !start_p;
    assign cmp_hit   = step_now && cmp_arm && (next_step == cmp_q);

    always_ff @(posedge clk) begin
        if (rst || swr_p) begin
            count_q <= '0;
        end else if (ovw_p) begin
            count_q <= ovw_val;
        end else if (start_p) begin
            count_q <= start_val;
        end else if (step_now) begin
            count_q <= next_step;
        end
    end

    // A compare event in the same cycle as an acknowledge wins
    always_ff @(posedge clk) begin
        if (rst || swr_p) begin
            status_q <= 1'b0;
        end else if (cmp_hit) begin
            status_q <= 1'b1;
        end else if (stat_clr_p) begin
            status_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ctm_regs.sv
module ctm_regs
    import ctm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic [DW-1:0]     count_q,
    input  logic              status_q,
    output ctrl_t             ctrl_q,
    output logic [DW-1:0]     load_q,
    output logic [DW-1:0]     cmp_q,
    output logic [DW-1:0]     bus_rdata,
    output logic              swr_p,
    output logic              start_p,
    output logic [DW-1:0]     start_val,
    output logic              ovw_p,
    output logic              stat_clr_p
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             unused_addr_lsb;
    logic             wr_en;
    logic             wr_ctrl, wr_stat, wr_load, wr_cmp;
    ctrl_t            new_ctrl;
    ctrl_t            kept_ctrl;

    assign word_idx        = bus_addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^bus_addr[1:0];
    assign wr_en           = bus_sel && bus_wr;
    assign wr_ctrl         = wr_en && (word_idx == IDX_W'(REG_CTRL));
    assign wr_stat         = wr_en && (word_idx == IDX_W'(REG_STAT));
    assign wr_load         = wr_en && (word_idx == IDX_W'(REG_LOAD));
    assign wr_cmp          = wr_en && (word_idx == IDX_W'(REG_CMP));

    assign new_ctrl  = ctrl_from_word(bus_wdata);
    assign kept_ctrl = ctrl_t'(new_ctrl & SWR_KEEP);

    assign swr_p      = wr_ctrl && new_ctrl.swr;
    assign start_p    = wr_ctrl && !new_ctrl.swr && new_ctrl.en &&
                        !ctrl_q.en && new_ctrl.start_mode;
    assign start_val  = new_ctrl.reload ? load_q : '1;
    assign ovw_p      = wr_load && ctrl_q.ovw;
    assign stat_clr_p = wr_stat && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            load_q <= '1;
            cmp_q  <= '0;
        end else begin
            if (wr_ctrl) begin
                if (new_ctrl.swr) begin
                    ctrl_q <= kept_ctrl;
                end else begin
                    ctrl_q     <= new_ctrl;
                    ctrl_q.swr <= 1'b0;
                end
            end
            if (swr_p) begin
                load_q <= '1;
                cmp_q  <= '0;
            end else begin
                if (wr_load) load_q <= bus_wdata;
                if (wr_cmp)  cmp_q  <= bus_wdata;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (word_idx == IDX_W'(REG_CTRL))      bus_rdata = DW'(ctrl_q);
        else if (word_idx == IDX_W'(REG_STAT)) bus_rdata = DW'(status_q);
        else if (word_idx == IDX_W'(REG_LOAD)) bus_rdata = load_q;
        else if (word_idx == IDX_W'(REG_CMP))  bus_rdata = cmp_q;
        else if (word_idx == IDX_W'(REG_CNT))  bus_rdata = count_q;
    end

endmodule

// File: rtl/ctm_timer.sv
module ctm_timer
    import ctm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              src_en_per,
    input  logic              src_en_fast,
    input  logic              src_en_slow,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq
);
    ctrl_t         ctrl_q;
    logic [DW-1:0] load_q, cmp_q, count_q, start_val;
    logic          status_q, tick;
    logic          swr_p, start_p, ovw_p, stat_clr_p;

    ctm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .count_q    (count_q),
        .status_q   (status_q),
        .ctrl_q     (ctrl_q),
        .load_q     (load_q),
        .cmp_q      (cmp_q),
        .bus_rdata  (bus_rdata),
        .swr_p      (swr_p),
        .start_p    (start_p),
        .start_val  (start_val),
        .ovw_p      (ovw_p),
        .stat_clr_p (stat_clr_p)
    );

    ctm_prescale u_presc (
        .clk         (clk),
        .rst         (rst),
        .en          (ctrl_q.en),
        .src         (ctrl_q.clk_src),
        .presc       (ctrl_q.presc),
        .src_en_per  (src_en_per),
        .src_en_fast (src_en_fast),
        .src_en_slow (src_en_slow),
        .tick        (tick)
    );

    ctm_counter u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .swr_p      (swr_p),
        .start_p    (start_p),
        .start_val  (start_val),
        .ovw_p      (ovw_p),
        .ovw_val    (bus_wdata),
        .reload     (ctrl_q.reload),
        .load_q     (load_q),
        .cmp_q      (cmp_q),
        .cmp_arm    (ctrl_q.en && ctrl_q.cmp_ie),
        .stat_clr_p (stat_clr_p),
        .count_q    (count_q),
        .status_q   (status_q)
    );

    assign irq = status_q && ctrl_q.en && ctrl_q.cmp_ie;

endmodule

// File: rtl/ctm_timer_chk.sv
module ctm_timer_chk
    import ctm_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DW-1:0]     bus_wdata,
    input logic              irq,
    input logic              tick,
    input ctrl_t             ctrl_q,
    input logic [DW-1:0]     load_q,
    input logic [DW-1:0]     count_q,
    input logic              status_q
);
    logic [ADDR_W-3:0] widx;
    logic              wr_any, wr_ctrl_chk;

    assign widx        = bus_addr[ADDR_W-1:2];
    assign wr_any      = bus_sel && bus_wr;
    assign wr_ctrl_chk = wr_any && (widx == '0);

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.en && !wr_any) |=> $stable(count_q)); // R10

    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (tick && count_q != '0 && !wr_any) |=> (count_q == $past(count_q) - DW'(1))); // R9

    AST_WRAP_ONES: assert property (@(posedge clk) disable iff (rst)
        (tick && count_q == '0 && !ctrl_q.reload && !wr_any) |=> (count_q == '1)); // R9

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (status_q && !wr_any) |=> status_q); // R5

    AST_SWR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl_chk && bus_wdata[16]) |=> (count_q == '0 && load_q == '1 && !status_q)); // R6

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        (tick && ctrl_q.presc != '0 && !wr_any) |=> !tick); // R3

    AST_FLAG_ARMED: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q) |-> $past(ctrl_q.en && ctrl_q.cmp_ie)); // R11

    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_ctrl_chk && (!bus_wdata[0] || !bus_wdata[2])) |=> !irq); // R4

endmodule

bind ctm_timer ctm_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .tick      (tick),
    .ctrl_q    (ctrl_q),
    .load_q    (load_q),
    .count_q   (count_q),
    .status_q  (status_q)
);

// File: tb/ctm_timer_bench.sv
module ctm_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;

    localparam logic [31:0] B_EN    = 32'h0000_0001;
    localparam logic [31:0] B_MODE  = 32'h0000_0002;
    localparam logic [31:0] B_IE    = 32'h0000_0004;
    localparam logic [31:0] B_RLD   = 32'h0000_0008;
    localparam logic [31:0] B_SWR   = 32'h0001_0000;
    localparam logic [31:0] B_OVW   = 32'h0002_0000;
    localparam logic [31:0] B_DBG   = 32'h0004_0000;
    localparam logic [31:0] S_PER   = 32'h0100_0000;
    localparam logic [31:0] S_FAST  = 32'h0200_0000;

    localparam logic [7:0] A_CTRL = 8'h00;
    localparam logic [7:0] A_STAT = 8'h04;
    localparam logic [7:0] A_LOAD = 8'h08;
    localparam logic [7:0] A_CMP  = 8'h0C;
    localparam logic [7:0] A_CNT  = 8'h10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              src_en_per = 1'b0, src_en_fast = 1'b0, src_en_slow = 1'b0;
    logic              bus_sel = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctm_timer #(.ADDR_W(ADDR_W)) u_ctm_timer (
        .clk         (clk),
        .rst         (rst),
        .src_en_per  (src_en_per),
        .src_en_fast (src_en_fast),
        .src_en_slow (src_en_slow),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq         (irq)
    );

    // Monitor: compares design outputs against queued expectations
    initial begin
        forever begin
            item_t it;
            logic [31:0] act;
            wait (q.size() != 0);
            it  = q.pop_front();
            act = it.is_irq ? {31'd0, irq} : bus_rdata;
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
        item_t it;
        @(negedge clk);
        bus_addr = a;
        #1;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        q.push_back(it);
        #1;
    endtask

    task automatic expect_irq(input logic e, input string tag);
        item_t it;
        @(negedge clk);
        #1;
        it.is_irq = 1'b1; it.exp = {31'd0, e}; it.tag = tag;
        q.push_back(it);
        #1;
    endtask

    // which: 0 peripheral, 1 fast
    task automatic pulse(input int which, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (which == 0) src_en_per = 1'b1; else src_en_fast = 1'b1;
            @(negedge clk);
            src_en_per = 1'b0; src_en_fast = 1'b0;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R12 reset values
        expect_rd(A_CTRL, 32'h0, "R12 ctrl");
        expect_rd(A_STAT, 32'h0, "R12 status");
        expect_rd(A_LOAD, 32'hFFFF_FFFF, "R12 load");
        expect_rd(A_CMP,  32'h0, "R12 cmp");
        expect_rd(A_CNT,  32'h0, "R12 count");
        expect_irq(1'b0, "R12 irq");

        // R2 masking, R7 start from all-ones load value
        wr(A_CTRL, 32'hFFFE_FFFF);
        expect_rd(A_CTRL, 32'h03FE_FFFF, "R2 ctrl mask");
        expect_rd(A_CNT, 32'hFFFF_FFFF, "R7 start reload from load");
        wr(A_CTRL, 32'h0);

        // R1 decode and holes
        wr(8'h14, 32'hDEAD_BEEF);
        expect_rd(8'h14, 32'h0, "R1 hole read");
        expect_rd(8'hFC, 32'h0, "R1 high hole read");
        wr(A_CMP, 32'h10);
        expect_rd(A_CMP, 32'h10, "R1 cmp readback");
        expect_rd(A_LOAD, 32'hFFFF_FFFF, "R1 hole write ignored");

        // R8 overwrite on/off
        wr(A_CTRL, B_OVW);
        wr(A_LOAD, 32'h20);
        expect_rd(A_CNT, 32'h20, "R8 overwrite count");
        wr(A_CTRL, B_RLD);
        wr(A_LOAD, 32'h30);
        expect_rd(A_CNT, 32'h20, "R8 count kept");
        expect_rd(A_LOAD, 32'h30, "R8 load updated");

        // R10 disabled hold
        wr(A_CTRL, S_PER);
        pulse(0, 5);
        expect_rd(A_CNT, 32'h20, "R10 hold when disabled");

        // R9 / R3 counting and prescaler
        wr(A_CTRL, B_EN | S_PER);
        pulse(0, 5);
        expect_rd(A_CNT, 32'h1B, "R9 decrement");
        wr(A_CTRL, B_EN | S_PER | (32'd2 << 4));
        pulse(0, 6);
        expect_rd(A_CNT, 32'h19, "R3 divide by three");
        pulse(0, 2);
        expect_rd(A_CNT, 32'h19, "R3 partial prescale");
        wr(A_CTRL, B_EN | S_FAST);
        pulse(0, 3);
        expect_rd(A_CNT, 32'h19, "R3 unselected source");
        pulse(1, 1);
        expect_rd(A_CNT, 32'h18, "R3 fast source");
        wr(A_CTRL, B_EN);
        pulse(0, 2);
        pulse(1, 2);
        expect_rd(A_CNT, 32'h18, "R3 source off");

        // R9 wrap and reload
        wr(A_CTRL, B_EN | B_OVW | S_PER);
        wr(A_LOAD, 32'h2);
        pulse(0, 3);
        expect_rd(A_CNT, 32'hFFFF_FFFF, "R9 wrap to ones");
        wr(A_CTRL, B_EN | B_RLD | B_OVW | S_PER);
        wr(A_LOAD, 32'h2);
        pulse(0, 3);
        expect_rd(A_CNT, 32'h2, "R9 reload from load");

        // R7 start modes
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, B_EN | B_MODE | S_PER);
        expect_rd(A_CNT, 32'hFFFF_FFFF, "R7 start free-run");
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, B_EN | B_MODE | B_RLD | S_PER);
        expect_rd(A_CNT, 32'h2, "R7 start reload");

        // R11 / R4 / R5 compare flag and interrupt
        wr(A_CTRL, B_EN | B_IE | B_OVW | S_PER);
        wr(A_CMP, 32'h3);
        wr(A_LOAD, 32'h5);
        pulse(0, 1);
        expect_rd(A_STAT, 32'h0, "R11 no match yet");
        expect_irq(1'b0, "R4 irq low without flag");
        pulse(0, 1);
        expect_rd(A_STAT, 32'h1, "R11 match sets flag");
        expect_irq(1'b1, "R4 irq high");
        wr(A_CTRL, B_EN | B_OVW | S_PER);
        expect_irq(1'b0, "R4 irq gated by enable bit 2");
        expect_rd(A_STAT, 32'h1, "R5 flag stays");
        wr(A_CTRL, B_EN | B_IE | B_OVW | S_PER);
        expect_irq(1'b1, "R4 irq back");
        wr(A_STAT, 32'h0);
        expect_rd(A_STAT, 32'h1, "R5 zero write ignored");
        wr(A_STAT, 32'h1);
        expect_rd(A_STAT, 32'h0, "R5 ack clears");
        expect_irq(1'b0, "R4 irq after ack");
        wr(A_CTRL, B_EN | B_OVW | S_PER);
        wr(A_LOAD, 32'h4);
        pulse(0, 1);
        expect_rd(A_STAT, 32'h0, "R11 not armed");
        wr(A_CTRL, B_EN | B_IE | B_OVW | S_PER);
        wr(A_LOAD, 32'h4);
        pulse(0, 1);
        expect_irq(1'b1, "R11 armed match");
        wr(A_CTRL, B_IE | B_OVW | S_PER);
        expect_irq(1'b0, "R4 irq gated by enable bit 0");

        // R6 software reset
        wr(A_LOAD, 32'h55);
        wr(A_CMP, 32'h7);
        wr(A_CTRL, B_EN | B_MODE | B_SWR | B_DBG | (32'd5 << 4) | S_PER | B_IE);
        expect_rd(A_CTRL, 32'h0004_0003, "R6 ctrl kept bits");
        expect_rd(A_STAT, 32'h0, "R6 status cleared");
        expect_rd(A_LOAD, 32'hFFFF_FFFF, "R6 load ones");
        expect_rd(A_CMP, 32'h0, "R6 cmp cleared");
        expect_rd(A_CNT, 32'h0, "R6 count cleared");

        wait (q.size() == 0);
        #1;
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule